// File: doc/BRIEF.md
# Bit-Serial EEPROM Protocol Engine

This block is the device-side logic of a small nonvolatile memory that moves one bit per bus cycle over a single data pin. The host drives three active-low strobes (chip enable, output enable, write enable) and uses them like an ordinary parallel bus. Each completed write cycle hands one bit to the device, and each completed read cycle takes one bit from it. The engine samples the strobes in its own clock domain and decodes the cycle kinds. It then walks through four steps: an unlock pattern, a serial address, page loading or sequential reading, and a three-cycle commit trigger.

The storage is a 512-byte register array with an 8-byte page buffer in front of it. The nonvolatile program time is modelled as a busy period of a fixed number of clock cycles. During that period the data pin reports progress to any read cycle. A host writes by unlocking, sending an address and one or more whole bytes, and then issuing the trigger. It reads by unlocking, sending an address and clocking bits out.

Top module: `serial_eeprom_core`

## Requirements
- R1: After reset, a read cycle outside any read-data phase returns 1 on the data pin (not busy), and the array holds 0xFF in every byte.
- R2: RST_READS consecutive read cycles, each ended by chip enable rising while output enable is low and write enable is high, unlock the engine and place it in address loading. Any other completed cycle in between restarts the count.
- R3: The address is taken from the next 16 write cycles, most significant bit first. Only the last 9 bits form the byte address; the first 7 have no effect.
- R4: After the address, read cycles return the addressed byte with bit 7 first. Further reads continue through the following bytes, and the address wraps from 511 to 0.
- R5: Write cycles after the address load bytes, bit 7 first, into page slots starting at the address's low 3 bits. The slot index wraps inside the aligned 8-byte page, so a later byte overwrites an earlier one. A commit changes only the slots that received a byte.
- R6: A read, then a write of 1, then a read, issued right after a whole number of loaded bytes, starts the program period. The array shows the new bytes once that period ends.
- R7: Ending page load with a read after a bit count that is not a multiple of 8 starts no program period and leaves the array unchanged.
- R8: A commit trigger whose middle write carries 0 starts no program period and leaves the array unchanged.
- R9: During the program period a read cycle returns 0. The period lasts BUSY_CYCLES clocks, after which reads return 1. An unlock pattern issued during the period neither shortens it nor changes this.
- R10: A read cycle during address loading aborts the sequence. Later writes and triggers change nothing until the next unlock.
- R11: Completing a program period clears the write enable latch, so an address, data and trigger sent afterwards without a new unlock change nothing.
- R12: Strobe activity while chip enable is high has no effect on the engine and never enables the data pin driver.
- R13: The data pin driver is enabled only while chip enable and output enable are low and write enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock used to sample all bus signals |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable strobe, active low |
| oeN | input | 1 | Output enable strobe, active low |
| weN | input | 1 | Write enable strobe, active low |
| ioIn | input | 1 | Serial data pin as driven by the host |
| ioOut | output | 1 | Serial data the device drives back |
| ioOe | output | 1 | Driver enable for ioOut |

## Verification
A state register that drifts shows up at the data pin at the next read cycle. A read in the wrong phase returns a status 1 where a data bit was expected, or the reverse. A wrong slot pointer or a lost latch stays hidden until the program period ends, and it then appears as a mismatching byte in the next sequential read-back. For this reason every write scenario is followed by an immediate status read and a full read-back of the affected page compared against a bench model of the array.

// File: rtl/sepk.sv
package sepk;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_SEL, S_LOAD, S_RD, S_C1, S_C2, S_BUSY
  } stateT;

  typedef struct packed {
    logic addrShift;
    logic dataShift;
    logic readStep;
    logic pageClear;
    logic commit;
    logic dataMode;
    logic busy;
    logic bitVal;
  } strobeT;
endpackage

// File: rtl/se_bus_sync.sv
module se_bus_sync (
  input  logic clk,
  input  logic rstN,
  input  logic ceN,
  input  logic oeN,
  input  logic weN,
  input  logic ioIn,
  output logic wrEnd,
  output logic rdEnd,
  output logic framed,
  output logic wrBit,
  output logic rdWin
);
  logic [1:0] ceQ, oeQ, weQ, ioQ;
  logic ceS, oeS, weS;
  logic actP, weP, ioP;
  logic active, endEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ <= 2'b11; oeQ <= 2'b11; weQ <= 2'b11; ioQ <= 2'b00;
      actP <= 1'b0; weP <= 1'b1; ioP <= 1'b0;
    end else begin
      ceQ <= {ceQ[0], ceN};
      oeQ <= {oeQ[0], oeN};
      weQ <= {weQ[0], weN};
      ioQ <= {ioQ[0], ioIn};
      actP <= active;
      weP <= weS;
      ioP <= ioQ[1];
    end
  end

  assign ceS    = ceQ[1];
  assign oeS    = oeQ[1];
  assign weS    = weQ[1];
  assign active = !ceS && (!weS || !oeS);
  assign endEv  = actP && !active;
  assign wrEnd  = endEv && !weP;
  assign rdEnd  = endEv && weP;
  assign framed = ceS;
  assign wrBit  = ioP;
  assign rdWin  = !ceS && !oeS && weS;

  // R12: no cycle completes while chip enable has been high for two samples
  a_r12_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
    (ceS && $past(ceS)) |-> (!wrEnd && !rdEnd));
  // R12: a cycle end is a single-clock event
  a_r12_single_event: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnd || rdEnd) |=> !(wrEnd || rdEnd));
endmodule

// File: rtl/se_ctrl.sv
module se_ctrl #(
  parameter int ADDR_BITS   = 16,
  parameter int RST_READS   = 4,
  parameter int BUSY_CYCLES = 400
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEnd,
  input  logic        rdEnd,
  input  logic        framed,
  input  logic        wrBit,
  output sepk::strobeT st
);
  import sepk::*;
  localparam int ACW = $clog2(ADDR_BITS);
  localparam int RCW = $clog2(RST_READS + 1);
  localparam int BCW = $clog2(BUSY_CYCLES + 1);

  stateT          state;
  logic [ACW-1:0] addrCnt;
  logic [2:0]     loadLow;
  logic [RCW-1:0] rstCnt;
  logic [BCW-1:0] busyCnt;
  logic           wel;
  logic           rstEvent, busyDone, inBusy;

  assign inBusy   = (state == S_BUSY);
  assign rstEvent = rdEnd && framed && (rstCnt == RCW'(RST_READS - 1));
  assign busyDone = inBusy && (busyCnt == BCW'(BUSY_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstCnt <= '0;
    else if (rdEnd && framed) rstCnt <= rstEvent ? '0 : rstCnt + 1'b1;
    else if (wrEnd || rdEnd) rstCnt <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; addrCnt <= '0; loadLow <= '0; busyCnt <= '0; wel <= 1'b0;
    end else if (inBusy) begin
      busyCnt <= busyCnt + 1'b1;
      if (busyDone) begin
        state <= S_IDLE;
        wel   <= 1'b0;
      end
    end else if (rstEvent) begin
      state   <= S_ADDR;
      wel     <= 1'b1;
      addrCnt <= '0;
    end else if (wrEnd) begin
      unique case (state)
        S_ADDR: begin
          addrCnt <= addrCnt + 1'b1;
          if (addrCnt == ACW'(ADDR_BITS - 1)) state <= S_SEL;
        end
        S_SEL:  begin state <= S_LOAD; loadLow <= 3'd1; end
        S_LOAD: loadLow <= loadLow + 1'b1;
        S_C1:   state <= wrBit ? S_C2 : S_IDLE;
        S_RD, S_C2: state <= S_IDLE;
        default: ;
      endcase
    end else if (rdEnd) begin
      unique case (state)
        S_ADDR: state <= S_IDLE;
        S_SEL:  state <= S_RD;
        S_LOAD: state <= (loadLow == 3'd0) ? S_C1 : S_IDLE;
        S_C1:   state <= S_IDLE;
        S_C2: begin
          if (wel) begin
            state   <= S_BUSY;
            busyCnt <= '0;
          end else begin
            state <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    st.addrShift = wrEnd && (state == S_ADDR);
    st.dataShift = wrEnd && ((state == S_SEL) || (state == S_LOAD));
    st.readStep  = rdEnd && ((state == S_SEL) || (state == S_RD));
    st.pageClear = rstEvent && !inBusy;
    st.commit    = busyDone;
    st.dataMode  = (state == S_SEL) || (state == S_RD);
    st.busy      = inBusy;
    st.bitVal    = wrBit;
  end

  // R6: a program period only begins with the latch set
  a_r6_start_needs_latch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inBusy) |-> $past(wel));
  // R11: the latch is gone once programming finishes
  a_r11_latch_cleared: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inBusy) |-> !wel);
  // R2: an unlock outside programming lands in address loading with the latch set
  a_r2_unlock_to_addr: assert property (@(posedge clk) disable iff (!rstN)
    (rstEvent && !inBusy) |=> (state == S_ADDR) && wel);
  // R9: programming is not cut short by any bus activity
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (inBusy && !busyDone) |=> inBusy);
endmodule

// File: rtl/se_dpath.sv
module se_dpath #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  sepk::strobeT st,
  output logic        dataBit
);
  localparam int PW    = $clog2(PAGE_BYTES);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0]     addrReg;
  logic [2:0]            bitIdx;
  logic [6:0]            byteSh;
  logic [7:0]            page [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid;
  logic [7:0]            mem  [DEPTH];

  assign dataBit = st.dataMode ? mem[addrReg][3'd7 - bitIdx] : !st.busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0; bitIdx <= '0; byteSh <= '0; valid <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) page[i] <= 8'h00;
    end else if (st.pageClear) begin
      bitIdx <= '0;
      valid  <= '0;
    end else if (st.addrShift) begin
      addrReg <= {addrReg[ADDR_W-2:0], st.bitVal};
    end else if (st.dataShift) begin
      byteSh <= {byteSh[5:0], st.bitVal};
      bitIdx <= bitIdx + 1'b1;
      if (bitIdx == 3'd7) begin
        page[addrReg[PW-1:0]]  <= {byteSh, st.bitVal};
        valid[addrReg[PW-1:0]] <= 1'b1;
        addrReg[PW-1:0]        <= addrReg[PW-1:0] + 1'b1;
      end
    end else if (st.readStep) begin
      bitIdx <= bitIdx + 1'b1;
      if (bitIdx == 3'd7) addrReg <= addrReg + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (st.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (valid[i]) mem[{addrReg[ADDR_W-1:PW], PW'(i)}] <= page[i];
    end
  end

  // R5: loading never moves the page base
  a_r5_page_base_held: assert property (@(posedge clk) disable iff (!rstN)
    st.dataShift |=> addrReg[ADDR_W-1:PW] == $past(addrReg[ADDR_W-1:PW]));
  // R9: status during programming reads low
  a_r9_status_low: assert property (@(posedge clk) disable iff (!rstN)
    (st.busy && !st.dataMode) |-> !dataBit);
endmodule

// File: rtl/serial_eeprom_core.sv
module serial_eeprom_core #(
  parameter int RST_READS   = 4,
  parameter int BUSY_CYCLES = 400,
  parameter int ADDR_BITS   = 16,
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceN,
  input  logic oeN,
  input  logic weN,
  input  logic ioIn,
  output logic ioOut,
  output logic ioOe
);
  logic wrEnd, rdEnd, framed, wrBit, rdWin;
  sepk::strobeT st;

  se_bus_sync uSync (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .ioIn(ioIn),
    .wrEnd(wrEnd), .rdEnd(rdEnd), .framed(framed), .wrBit(wrBit), .rdWin(rdWin)
  );

  se_ctrl #(.ADDR_BITS(ADDR_BITS), .RST_READS(RST_READS), .BUSY_CYCLES(BUSY_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEnd(wrEnd), .rdEnd(rdEnd), .framed(framed),
    .wrBit(wrBit), .st(st)
  );

  se_dpath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) uDpath (
    .clk(clk), .rstN(rstN), .st(st), .dataBit(ioOut)
  );

  assign ioOe = rdWin;
endmodule

// File: tb/tb_serial_eeprom_core.sv
module tb_serial_eeprom_core;
  localparam int RR = 4;
  localparam int BC = 400;

  logic clk = 1'b0;
  logic rstN, ceN, oeN, weN, ioIn;
  logic ioOut, ioOe;
  int checks = 0;
  int errors = 0;
  logic [7:0] model [512];
  logic [7:0] wdata [16];

  always #4 clk = ~clk;

  serial_eeprom_core #(.RST_READS(RR), .BUSY_CYCLES(BC)) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .ioIn(ioIn),
    .ioOut(ioOut), .ioOe(ioOe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic b);
    ceN = 1'b0; ioIn = b; waitN(3);
    weN = 1'b0; waitN(5);
    weN = 1'b1; waitN(5);
  endtask

  task automatic rd(output logic v, output logic en);
    ceN = 1'b0; oeN = 1'b0; waitN(6);
    v = ioOut; en = ioOe;
    oeN = 1'b1; waitN(5);
  endtask

  task automatic rdFramed();
    ceN = 1'b0; oeN = 1'b0; waitN(6);
    ceN = 1'b1; waitN(5);
    oeN = 1'b1; waitN(3);
  endtask

  task automatic unlock();
    for (int i = 0; i < RR; i++) rdFramed();
  endtask

  task automatic sendAddr(input logic [8:0] a, input logic [6:0] junk);
    logic [15:0] w;
    w = {junk, a};
    for (int i = 15; i >= 0; i--) wr(w[i]);
  endtask

  task automatic sendBytes(input int n);
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--) wr(wdata[k][b]);
  endtask

  task automatic trigger(input logic mid);
    logic v, en;
    rd(v, en); wr(mid); rd(v, en);
  endtask

  task automatic status(input logic exp, input string tag);
    logic v, en;
    rd(v, en);
    chk(v === exp && en === 1'b1, tag, {en, v}, {1'b1, exp});
  endtask

  task automatic modelWrite(input logic [8:0] a, input int n);
    int base, ptr;
    base = int'(a) & ~7;
    ptr = int'(a) & 7;
    for (int k = 0; k < n; k++) model[base + ((ptr + k) & 7)] = wdata[k];
  endtask

  task automatic readBack(input logic [8:0] a, input int n, input string tag);
    logic v, en;
    logic [7:0] got;
    unlock();
    sendAddr(a, 7'h55);
    for (int k = 0; k < n; k++) begin
      got = '0;
      for (int b = 0; b < 8; b++) begin
        rd(v, en);
        got = {got[6:0], v};
      end
      chk(got === model[(int'(a) + k) % 512], tag, got, model[(int'(a) + k) % 512]);
    end
  endtask

  // Full write: unlock, address, n bytes, trigger; checks busy and completion
  task automatic pageWrite(input logic [8:0] a, input int n, input string tag);
    unlock();
    sendAddr(a, 7'h2A);
    sendBytes(n);
    trigger(1'b1);
    status(1'b0, tag);
    waitN(BC + 40);
    status(1'b1, tag);
    modelWrite(a, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic v, en;
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    rstN = 1'b0; ceN = 1'b1; oeN = 1'b1; weN = 1'b1; ioIn = 1'b0;
    waitN(5);
    rstN = 1'b1;
    waitN(5);

    // R13: idle, no driver
    chk(ioOe === 1'b0, "R13 idle driver", ioOe, 0);
    // R1: status after reset
    status(1'b1, "R1 reset status");

    // R12: strobes with chip enable high
    ceN = 1'b1; waitN(4);
    for (int i = 0; i < 6; i++) begin
      ioIn = 1'b1; weN = 1'b0; oeN = 1'b0; waitN(6);
      chk(ioOe === 1'b0, "R12 deselected driver", ioOe, 0);
      weN = 1'b1; oeN = 1'b1; waitN(6);
    end

    // R1 R3 R4: erased content, junk upper address bits, wrap 511 to 0
    readBack(9'h1FE, 4, "R4 erased read wrap");

    // R5 R6 R9: five bytes from 0x1FD wrap inside page 0x1F8
    for (int k = 0; k < 5; k++) wdata[k] = 8'(8'h10 + k * 8'h11);
    unlock(); sendAddr(9'h1FD, 7'h7F); sendBytes(5); trigger(1'b1);
    status(1'b0, "R9 busy right after trigger");
    unlock();
    status(1'b0, "R9 unlock during busy");
    waitN(BC);
    status(1'b1, "R9 done after period");
    modelWrite(9'h1FD, 5);
    readBack(9'h1F6, 12, "R5 R6 page wrap readback");
    readBack(9'h1FF, 3, "R4 sequential wrap after write");

    // R5: ten bytes overwrite the first two slots
    for (int k = 0; k < 10; k++) wdata[k] = 8'(8'hA0 + k);
    pageWrite(9'h040, 10, "R5 overwrite busy");
    readBack(9'h040, 8, "R5 overwrite readback");

    // R7: partial byte then trigger
    for (int k = 0; k < 2; k++) wdata[k] = 8'h00;
    unlock(); sendAddr(9'h080, 7'h00); sendBytes(1);
    for (int b = 0; b < 4; b++) wr(1'b0);
    trigger(1'b1);
    status(1'b1, "R7 partial no busy");
    readBack(9'h080, 2, "R7 partial array unchanged");

    // R8: trigger with write 0
    unlock(); sendAddr(9'h081, 7'h00); sendBytes(2); trigger(1'b0);
    status(1'b1, "R8 bad trigger no busy");
    readBack(9'h080, 3, "R8 array unchanged");

    // R10: read inside the address phase
    unlock();
    for (int i = 0; i < 8; i++) wr(1'b0);
    rd(v, en);
    for (int i = 0; i < 8; i++) wr(1'b0);
    sendBytes(2); trigger(1'b1);
    status(1'b1, "R10 aborted no busy");
    readBack(9'h000, 2, "R10 array unchanged");

    // R11: after a finished write, a new sequence without unlock does nothing
    wdata[0] = 8'h5A;
    pageWrite(9'h100, 1, "R11 first write");
    sendAddr(9'h100, 7'h00); wdata[0] = 8'hC3; sendBytes(1); trigger(1'b1);
    status(1'b1, "R11 no busy without unlock");
    readBack(9'h100, 1, "R11 array kept");

    // R2: broken unlock pattern leaves the engine locked
    waitN(2);
    for (int i = 0; i < RR - 1; i++) rdFramed();
    wr(1'b0);
    rdFramed();
    sendAddr(9'h100, 7'h00); wdata[0] = 8'h3C; sendBytes(1); trigger(1'b1);
    status(1'b1, "R2 broken unlock no busy");
    readBack(9'h100, 1, "R2 array kept");

    // Random pages
    for (int it = 0; it < 8; it++) begin
      logic [8:0] a;
      int n;
      a = 9'($urandom_range(0, 511));
      n = int'($urandom_range(1, 10));
      for (int k = 0; k < n; k++) wdata[k] = 8'($urandom);
      pageWrite(a, n, "R6 random write");
      readBack({a[8:3], 3'b000}, 8, "R5 R6 random page readback");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule